// File: doc/BRIEF.md
# Floating-Point Exception Status and Error Pin

This block keeps the exception record of a floating-point unit. Each numeric operation can report any mix of six exception kinds: invalid operation, denormalized operand, zero divisor, overflow, underflow and inexact result. It can also report a register-stack fault. The block accumulates these reports in sticky flags. It compares the flags with six mask bits from the control word and from that derives an error-summary bit and a busy-mirror copy of it.

The block outputs a 16-bit status word and an active-low error pin. Software can restore the whole record through a load port, for example on an environment or state restore. On a load, the summary and mirror bits are recomputed from the restored flags and the current masks; they are never taken from the loaded data. A clear command empties the record. Arithmetic, rounding and masked default results belong to the datapath and are not handled here.

Top module: `fpu_exc_status`

## Requirements
- R1: Status bits 0..5 hold the flags in this order: invalid (0), denormal (1), zero divide (2), overflow (3), underflow (4), inexact (5). A report with `rpt_valid_i` high sets bit n of the flags at the next clock edge when bit n of `rpt_flags_i` is 1.
- R2: The flags are sticky. A report only ORs into them, and they drop only on a clear or a load. When a clear and a report come in the same cycle, the flags become exactly the report.
- R3: A report with `rpt_valid_i` and `rpt_stack_i` high sets status bit 6 (stack fault) and also status bit 0 (invalid). Bit 6 is sticky like the flags.
- R4: Status bit 7 (summary) is 1 exactly when some position n has flag n = 1 and `mask_i[n]` = 0. Mask bit n uses the same position as flag n. The bit follows a change of `mask_i` in the same cycle.
- R5: A load writes status bits 0..6 from `ld_data_i[6:0]` at the clock edge. Bits 7..15 of the loaded data are ignored. A load takes priority over a clear and a report in the same cycle.
- R6: Status bit 15 always equals status bit 7.
- R7: `err_no` is low exactly when status bit 7 is 1. This includes the cycle right after a load, and the pin returns high in the same cycle the summary clears.
- R8: Status bits 8..14 always read 0.
- R9: While reset is asserted, the status word is 0 and `err_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_valid_i | input | 1 | An operation's exception report is present |
| rpt_flags_i | input | 6 | Exception kinds raised by the operation |
| rpt_stack_i | input | 1 | Stack overflow or underflow raised by the operation |
| ld_valid_i | input | 1 | Load status word (environment/state restore) |
| ld_data_i | input | 16 | Status word being loaded |
| clr_i | input | 1 | Clear all exception flags |
| mask_i | input | 6 | Exception mask bits from the control word |
| status_o | output | 16 | Assembled status word |
| err_no | output | 1 | Error pin, active low |

## Verification
Two pairs of events can fall in the same cycle. A clear can meet a new exception report, and a load can meet a report, a clear or both. The bench drives these collisions directly, and it also lets them occur freely in a long random phase. A behavioural reference model gives load first priority, then applies the clear, then ORs in the report, and the model is compared with every field of the status word and the error pin on each cycle. Loads whose data sets bits 7 and 15 against the flags, and mask flips with no other activity, check that the summary and the pin come only from flags and masks.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
  localparam int unsigned NUM_EXC = 6;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned SF_POS  = 6;
  localparam int unsigned ES_POS  = 7;
  localparam int unsigned B_POS   = 15;
  localparam int unsigned IE_POS  = 0;
  localparam int unsigned REC_W   = NUM_EXC + 1;  // flags plus stack fault

  typedef logic [NUM_EXC-1:0] exc_vec_t;
  typedef logic [REC_W-1:0]   rec_vec_t;
endpackage

// File: rtl/exc_sticky_reg.sv
module exc_sticky_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= 1'b0;
      else if (ld_i)   q_q <= ld_val_i[i];
      else if (clr_i)  q_q <= set_i[i];
      else             q_q <= q_q | set_i[i];
    end
    assign q_o[i] = q_q;
  end

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !clr_i) |=> ((q_o & $past(q_o)) == $past(q_o)));

  assert_clr_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && clr_i) |=> (q_o == $past(set_i)));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/exc_summary.sv
module exc_summary #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         es_o
);
  logic [N-1:0] live;
  for (genvar i = 0; i < N; i++) begin : g_live
    assign live[i] = flags_i[i] & ~mask_i[i];
  end
  assign es_o = |live;
endmodule

// File: rtl/status_pack.sv
module status_pack
  import fpu_exc_pkg::*;
(
  input  exc_vec_t            flags_i,
  input  logic                sf_i,
  input  logic                es_i,
  output logic [STAT_W-1:0]   word_o,
  output logic                err_no
);
  always_comb begin
    word_o                  = '0;
    word_o[NUM_EXC-1:0]     = flags_i;
    word_o[SF_POS]          = sf_i;
    word_o[ES_POS]          = es_i;
    word_o[B_POS]           = es_i;
  end
  assign err_no = ~es_i;
endmodule

// File: rtl/fpu_exc_status.sv
module fpu_exc_status
  import fpu_exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rpt_valid_i,
  input  logic [5:0]        rpt_flags_i,
  input  logic              rpt_stack_i,
  input  logic              ld_valid_i,
  input  logic [15:0]       ld_data_i,
  input  logic              clr_i,
  input  logic [5:0]        mask_i,
  output logic [15:0]       status_o,
  output logic              err_no
);
  rec_vec_t set_vec, rec_q;
  exc_vec_t stack_ie;
  logic     es;
  logic     unused_ld_hi;

  assign unused_ld_hi = ^ld_data_i[STAT_W-1:REC_W];

  // stack fault also raises invalid operation
  always_comb begin
    stack_ie         = '0;
    stack_ie[IE_POS] = rpt_stack_i;
  end
  assign set_vec = rpt_valid_i ? {rpt_stack_i, rpt_flags_i | stack_ie} : '0;

  exc_sticky_reg #(.W(REC_W)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld_valid_i),
    .ld_val_i(ld_data_i[REC_W-1:0]),
    .clr_i   (clr_i),
    .set_i   (set_vec),
    .q_o     (rec_q)
  );

  exc_summary #(.N(NUM_EXC)) u_sum (
    .flags_i(rec_q[NUM_EXC-1:0]),
    .mask_i (mask_i),
    .es_o   (es)
  );

  status_pack u_pack (
    .flags_i(rec_q[NUM_EXC-1:0]),
    .sf_i   (rec_q[SF_POS]),
    .es_i   (es),
    .word_o (status_o),
    .err_no (err_no)
  );

  assert_stack_ie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i && rpt_stack_i && !ld_valid_i) |=> (status_o[IE_POS] && status_o[SF_POS]));

  assert_es_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ES_POS] |-> (|status_o[NUM_EXC-1:0]));

  assert_mask_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !status_o[ES_POS]);

  assert_mirror_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_POS] == status_o[ES_POS]);

  assert_err_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_no == !status_o[ES_POS]);

  assert_zero_mid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[B_POS-1:ES_POS+1] == '0);
endmodule

// File: tb/fpu_exc_status_tb.sv
module fpu_exc_status_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rpt_valid_i = 1'b0;
  logic [5:0]  rpt_flags_i = '0;
  logic        rpt_stack_i = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [15:0] ld_data_i = '0;
  logic        clr_i = 1'b0;
  logic [5:0]  mask_i = '0;
  logic [15:0] status_o;
  logic        err_no;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_flags = 0;
  int m_sf = 0;

  always #5 clk = ~clk;

  fpu_exc_status u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rpt_valid_i(rpt_valid_i), .rpt_flags_i(rpt_flags_i),
    .rpt_stack_i(rpt_stack_i), .ld_valid_i(ld_valid_i), .ld_data_i(ld_data_i),
    .clr_i(clr_i), .mask_i(mask_i), .status_o(status_o), .err_no(err_no)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    int es;
    es = ((m_flags & ~int'(mask_i)) & 'h3f) != 0 ? 1 : 0;
    chk({tag, " R1 flags"}, int'(status_o[5:0]), m_flags);
    chk({tag, " R3 stack fault"}, int'(status_o[6]), m_sf);
    chk({tag, " R4 summary"}, int'(status_o[7]), es);
    chk({tag, " R6 mirror"}, int'(status_o[15]), es);
    chk({tag, " R8 zero bits"}, int'(status_o[14:8]), 0);
    chk({tag, " R7 err pin"}, int'(err_no), 1 - es);
  endtask

  task automatic model_edge();
    if (ld_valid_i) begin
      m_flags = int'(ld_data_i[5:0]);
      m_sf    = int'(ld_data_i[6]);
    end else begin
      if (clr_i) begin m_flags = 0; m_sf = 0; end
      if (rpt_valid_i) begin
        m_flags = m_flags | int'(rpt_flags_i);
        if (rpt_stack_i) begin m_flags = m_flags | 1; m_sf = 1; end
      end
    end
  endtask

  // called at a negedge: drive, take the edge, check at the following negedge
  task automatic cyc(bit ld, logic [15:0] ldd, bit clr, bit rv, logic [5:0] rf,
                     bit rs, logic [5:0] msk, string tag);
    ld_valid_i = ld; ld_data_i = ldd; clr_i = clr;
    rpt_valid_i = rv; rpt_flags_i = rf; rpt_stack_i = rs; mask_i = msk;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset word", int'(status_o), 0);
    chk("R9 reset pin", int'(err_no), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    cmp("R9 after release");

    // R1: each flag position, all masked so pin stays high
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 6'(1 << i), 0, 6'h3f, "R1 single");
    // R4: unmask one by one
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 6'(~(1 << i)), "R4 unmask");
    cyc(0, 0, 0, 0, 0, 0, 6'h3f, "R7 pin release on mask");
    // R2: clear and report in same cycle
    cyc(0, 0, 1, 1, 6'h04, 0, 6'h00, "R2 clr+rpt");
    cyc(0, 0, 0, 1, 6'h10, 0, 6'h00, "R2 sticky or");
    cyc(0, 0, 0, 0, 0, 0, 6'h00, "R2 hold");
    cyc(0, 0, 1, 0, 0, 0, 6'h00, "R2 clear");
    // R3: stack fault
    cyc(0, 0, 0, 1, 6'h00, 1, 6'h01, "R3 stack");
    cyc(0, 0, 0, 1, 6'h00, 1, 6'h00, "R3 stack unmasked");
    cyc(0, 0, 1, 0, 0, 0, 6'h00, "R2 clear stack");
    // R5: load ignores bits 7 and 15, priority over clear and report
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 6'h3f, "R5 load all masked");
    cyc(1, 16'h0001, 1, 1, 6'h3e, 1, 6'h00, "R5 R7 load wins");
    cyc(1, 16'h8080, 0, 0, 0, 0, 6'h00, "R5 load es only");
    cyc(1, 16'h0060, 0, 0, 0, 0, 6'h00, "R5 load sf pe");

    for (int n = 0; n < 1500; n++) begin
      logic [5:0] msk;
      msk = ($urandom % 4 == 0) ? 6'($urandom) : mask_i;
      cyc($urandom % 8 == 0, 16'($urandom), $urandom % 8 == 0, $urandom % 2 == 0,
          6'($urandom) & 6'($urandom), $urandom % 8 == 0, msk, "random R2 R5");
    end

    // R9: reset again mid-run
    rst_ni = 1'b0;
    #1;
    chk("R9 async reset word", int'(status_o), 0);
    chk("R9 async reset pin", int'(err_no), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule